// File: doc/BRIEF.md
# Four-Phase Instruction Cycle Sequencer

This block sets the instruction-cycle timing of a small 8-bit microcontroller core. It splits the oscillator clock into instruction cycles of four oscillator periods each, and shows the running quarter on a one-hot phase bus, Q1 through Q4. A strobe marks the last quarter of every instruction cycle, so downstream logic commits its results there.

Most instructions finish in one instruction cycle. Three conditions add a second cycle, and that second cycle is flagged as a NOP so that the core executes nothing in it. The conditions are a conditional test that came out true, a write to the program counter, and a table read or write. The decoder raises these conditions on three request inputs. The sequencer samples them only on the clock edge that closes Q4 of an executing cycle. Any mix of requests adds exactly one NOP cycle. The cycle that starts out of reset is also a NOP cycle, so nothing runs before the first fetch has completed.

Top module: `insn_cycle_seq`

## Requirements
- R1: The `phase` output is always one-hot, with bit 0 = Q1, bit 1 = Q2, bit 2 = Q3 and bit 3 = Q4. Once reset is released it advances one bit per clock in the order Q1, Q2, Q3, Q4, Q1 and so on.
- R2: `cycle_strobe` is high exactly in the clock periods where `phase` shows Q4, which is once in every four clocks.
- R3: While `rst` is high, and in the first clock after it is released, `phase` is 4'b0001 (Q1) and `nop_cycle` is 1. The cycle that begins at reset release is a NOP cycle, and this holds when reset arrives mid-cycle.
- R4: `nop_cycle` keeps one value for all four phases of a cycle. It can change only between Q4 and the next Q1.
- R5: The request inputs are sampled only at the clock edge that ends Q4. Requests raised in Q1 to Q3 and dropped before Q4 have no effect on the next cycle.
- R6: When `cond_true` is high in Q4 of an executing cycle (`nop_cycle` = 0), the next cycle has `nop_cycle` = 1.
- R7: When `pc_change` is high in Q4 of an executing cycle, the next cycle has `nop_cycle` = 1.
- R8: When `table_op` is high in Q4 of an executing cycle, the next cycle has `nop_cycle` = 1.
- R9: Any combination of requests, including all three at once, adds exactly one NOP cycle. When no request is high at Q4 of an executing cycle, the next cycle executes (`nop_cycle` = 0).
- R10: Requests seen at Q4 of a NOP cycle are ignored. The cycle after a NOP cycle always has `nop_cycle` = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous reset, active high |
| cond_true | input | 1 | Conditional test of the current instruction is true |
| pc_change | input | 1 | Current instruction writes the program counter |
| table_op | input | 1 | Current instruction is a table read or table write |
| phase | output | 4 | One-hot phase, bit 0 = Q1 through bit 3 = Q4 |
| cycle_strobe | output | 1 | High during Q4 of every instruction cycle |
| nop_cycle | output | 1 | The current instruction cycle is a forced NOP |

## Verification
A corrupted phase ring shows at the ports on the very next clock. Either the phase bus loses its one-hot form, or the strobe slips away from the fourth step after Q1. A wrong cycle-kind state cannot show within a cycle, because `nop_cycle` is held for four clocks. It shows one clock after the Q4 edge, as a NOP that was never requested, a NOP that was requested but is missing, or two NOP cycles in a row. The bench therefore checks every phase of every cycle, and includes requests made in the wrong phase and requests made during a NOP cycle.

// File: rtl/isc_pkg.sv
package isc_pkg;

    localparam int unsigned NUM_PHASES = 4;

    typedef logic [NUM_PHASES-1:0] phase_t;

    localparam phase_t PH_FIRST = phase_t'(1);
    localparam phase_t PH_LAST  = phase_t'(1) << (NUM_PHASES - 1);

    typedef enum logic {
        CYC_EXEC = 1'b0,
        CYC_NOP  = 1'b1
    } cyc_kind_t;

    // One bit per reason an instruction may need a second cycle
    typedef struct packed {
        logic tbl;
        logic pc;
        logic cond;
    } ext_req_t;

    function automatic phase_t rotate_phase(phase_t p);
        return {p[NUM_PHASES-2:0], p[NUM_PHASES-1]};
    endfunction

    function automatic logic wants_extra(ext_req_t r);
        return |r;
    endfunction

endpackage

// File: rtl/isc_phase_ring.sv
module isc_phase_ring #(
    parameter int unsigned WIDTH = isc_pkg::NUM_PHASES
) (
    input  logic             clk,
    input  logic             rst,
    output logic [WIDTH-1:0] ring,
    output logic             at_last
);

    // One flop per phase; reset loads the first position
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        localparam int unsigned PREV = (i == 0) ? WIDTH - 1 : i - 1;
        always_ff @(posedge clk) begin
            if (rst) ring[i] <= 1'(i == 0);
            else     ring[i] <= ring[PREV];
        end
    end

    assign at_last = ring[WIDTH-1];

endmodule

// File: rtl/isc_extend_ctrl.sv
module isc_extend_ctrl
    import isc_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      boundary,
    input  ext_req_t  req,
    output cyc_kind_t kind
);

    cyc_kind_t kind_q;
    cyc_kind_t kind_d;

    always_comb begin
        kind_d = kind_q;
        if (boundary) begin
            if (kind_q == CYC_EXEC && wants_extra(req)) kind_d = CYC_NOP;
            else                                        kind_d = CYC_EXEC;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) kind_q <= CYC_NOP;
        else     kind_q <= kind_d;
    end

    assign kind = kind_q;

endmodule

// File: rtl/insn_cycle_seq.sv
module insn_cycle_seq
    import isc_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  cond_true,
    input  logic                  pc_change,
    input  logic                  table_op,
    output logic [NUM_PHASES-1:0] phase,
    output logic                  cycle_strobe,
    output logic                  nop_cycle
);

    ext_req_t  req;
    cyc_kind_t kind;
    logic      last_q;

    assign req = '{tbl: table_op, pc: pc_change, cond: cond_true};

    isc_phase_ring #(.WIDTH(NUM_PHASES)) u_ring (
        .clk     (clk),
        .rst     (rst),
        .ring    (phase),
        .at_last (last_q)
    );

    isc_extend_ctrl u_ext (
        .clk      (clk),
        .rst      (rst),
        .boundary (last_q),
        .req      (req),
        .kind     (kind)
    );

    assign cycle_strobe = last_q;
    assign nop_cycle    = (kind == CYC_NOP);

endmodule

// File: rtl/isc_chk.sv
module isc_chk (
    input logic       clk,
    input logic       rst,
    input logic       cond_true,
    input logic       pc_change,
    input logic       table_op,
    input logic [3:0] phase,
    input logic       cycle_strobe,
    input logic       nop_cycle
);

    // R1
    one_hot_phase_chk: assert property (@(posedge clk) disable iff (rst)
        $countones(phase) == 1);

    // R1
    phase_rotate_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> phase == {$past(phase[2:0]), $past(phase[3])});

    // R2
    strobe_then_q1_chk: assert property (@(posedge clk) disable iff (rst)
        cycle_strobe |=> phase[0] && !cycle_strobe);

    // R3
    reset_state_chk: assert property (@(posedge clk)
        rst |=> phase == 4'b0001 && nop_cycle);

    // R4
    nop_stable_chk: assert property (@(posedge clk) disable iff (rst)
        !phase[3] |=> $stable(nop_cycle));

    // R6 R7 R8
    extend_req_chk: assert property (@(posedge clk) disable iff (rst)
        (phase[3] && !nop_cycle && (cond_true || pc_change || table_op)) |=> nop_cycle);

    // R9
    no_req_exec_chk: assert property (@(posedge clk) disable iff (rst)
        (phase[3] && !(cond_true || pc_change || table_op)) |=> !nop_cycle);

    // R10
    single_nop_chk: assert property (@(posedge clk) disable iff (rst)
        (phase[3] && nop_cycle) |=> !nop_cycle);

endmodule

bind insn_cycle_seq isc_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .cond_true    (cond_true),
    .pc_change    (pc_change),
    .table_op     (table_op),
    .phase        (phase),
    .cycle_strobe (cycle_strobe),
    .nop_cycle    (nop_cycle)
);

// File: tb/tb_insn_cycle_seq.sv
module tb_insn_cycle_seq;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cond_true = 1'b0;
    logic       pc_change = 1'b0;
    logic       table_op = 1'b0;
    logic [3:0] phase;
    logic       cycle_strobe;
    logic       nop_cycle;

    int n_checks = 0;
    int n_fail   = 0;

    always #5 clk = ~clk;

    insn_cycle_seq dut (
        .clk          (clk),
        .rst          (rst),
        .cond_true    (cond_true),
        .pc_change    (pc_change),
        .table_op     (table_op),
        .phase        (phase),
        .cycle_strobe (cycle_strobe),
        .nop_cycle    (nop_cycle)
    );

    // Each entry: {table_op, pc_change, cond_true, expected nop_cycle of that cycle}
    // Entry 0 is the cycle starting at reset release.
    localparam logic [3:0] VEC [12] = '{
        4'b1111,  // reset NOP cycle, requests ignored (R3, R10)
        4'b0000,  // execute
        4'b0010,  // execute with cond_true (R6)
        4'b0001,  // inserted NOP
        4'b0100,  // execute with pc_change (R7)
        4'b0001,  // inserted NOP
        4'b1000,  // execute with table_op (R8)
        4'b1111,  // NOP, requests ignored (R10)
        4'b1110,  // execute with all requests (R9)
        4'b0001,  // only one NOP (R9)
        4'b0000,  // execute
        4'b0000   // execute
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    // Checks one phase p of a cycle whose expected kind is exp_nop
    task automatic check_phase(input int p, input logic exp_nop);
        check(phase == 4'(1 << p), "R1", int'(phase), 1 << p);
        check(cycle_strobe == (p == 3), "R2", int'(cycle_strobe), int'(p == 3));
        check(nop_cycle == exp_nop, "R4", int'(nop_cycle), int'(exp_nop));
    endtask

    initial begin
        #200000;
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual 1 expected 0");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R3 reset state
        check(phase == 4'b0001, "R3", int'(phase), 1);
        check(nop_cycle == 1'b1, "R3", int'(nop_cycle), 1);
        check(cycle_strobe == 1'b0, "R3", int'(cycle_strobe), 0);
        rst = 1'b0;

        for (int v = 0; v < 12; v++) begin
            for (int p = 0; p < 4; p++) begin
                {table_op, pc_change, cond_true} = VEC[v][3:1];
                check_phase(p, VEC[v][0]);
                @(negedge clk);
            end
        end

        // R5: request raised in Q1..Q3 and dropped before Q4
        for (int p = 0; p < 4; p++) begin
            cond_true = (p != 3);
            pc_change = (p == 1);
            table_op  = (p == 0);
            check_phase(p, 1'b0);
            @(negedge clk);
        end
        cond_true = 1'b0;
        pc_change = 1'b0;
        table_op  = 1'b0;
        check(nop_cycle == 1'b0, "R5", int'(nop_cycle), 0);
        check(phase == 4'b0001, "R5", int'(phase), 1);

        // R3: reset arriving in Q3 of an executing cycle
        @(negedge clk);
        @(negedge clk);
        check(phase == 4'b0100, "R1", int'(phase), 4);
        rst = 1'b1;
        @(negedge clk);
        check(phase == 4'b0001, "R3", int'(phase), 1);
        check(nop_cycle == 1'b1, "R3", int'(nop_cycle), 1);
        rst = 1'b0;
        // Cycle after mid-run reset: NOP with a request at Q4, then execute (R10)
        for (int p = 0; p < 4; p++) begin
            cond_true = 1'b1;
            check_phase(p, 1'b1);
            @(negedge clk);
        end
        cond_true = 1'b0;
        check(nop_cycle == 1'b0, "R10", int'(nop_cycle), 0);

        finish_run();
    end

endmodule